// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block guards a 36-bit data port that is divided into four 9-bit byte lanes. Each lane has eight data bits and one parity bit in its top position. While the port is selected and not in a generating mailbox read, the block checks every lane of the incoming port word. If any lane has the wrong parity, it pulls an active-low error flag. A single static input chooses odd or even parity, and that choice applies to checking and to generation alike.

On reads, the block registers the outgoing word from one of two sources: the FIFO word or the mailbox word. When generation is enabled, the top bit of each lane is replaced by freshly computed parity. One set of four lane parity trees is shared between input checking and mailbox-read generation. While those trees generate, the error flag is forced inactive. FIFO reads draw generated parity from a second, dedicated set of trees.

The trees run in one of three named modes, decoded every cycle from the control pins:
- `TM_IDLE`: the port is deselected.
- `TM_CHECK`: the trees check the port word.
- `TM_MBX_GEN`: the trees generate parity for a mailbox read.

The mode changes as follows:
- IDLE→CHECK when `cs_n` falls.
- CHECK→MBX_GEN on a generating mailbox read.
- Any mode→IDLE when `cs_n` rises.

Top module: `lane_parity_top`

## Requirements
- R1: Lane k holds bits 9k+7..9k as data and bit 9k+8 as parity, for k = 0..3. In `TM_CHECK`, `err_n` is 0 in the same cycle whenever any lane of `port_din` fails its parity check, and 1 otherwise. This holds for writes and for reads that are not generating mailbox reads.
- R2: When `odd_sel`=1, a lane passes only if its 9 bits hold an odd count of ones. When `odd_sel`=0, a lane passes only if the count is even.
- R3: A read strobe is `cs_n`=0, `en`=1, `wr_sel`=0. With `gen_en`=1, `rd_dout` after the next rising `clk` equals the source word with each lane's bit 9k+8 replaced by parity computed over that lane's 8 data bits.
- R4: A generated parity bit makes its 9-bit lane hold an odd count of ones when `odd_sel`=1, and an even count when `odd_sel`=0.
- R5: With `gen_en`=0, a read strobe registers the source word unchanged, including its lane top bits.
- R6: When `cs_n`=0, `en`=1, `wr_sel`=0, `mbx_sel`=1 and `gen_en`=1, `err_n` is 1 whatever `port_din` holds.
- R7: While `cs_n`=1, `err_n` is 1.
- R8: `rst_n`=0 clears `rd_dout` to 0. Without a read strobe, `rd_dout` holds its value.
- R9: On a read strobe, `mbx_sel`=1 selects `mbox_word` as the source and `mbx_sel`=0 selects `fifo_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_din | input | 36 | Word presented on the port, checked for parity |
| fifo_word | input | 36 | FIFO word offered for a read |
| mbox_word | input | 36 | Mailbox word offered for a read |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| gen_en | input | 1 | 1 = insert generated parity on reads |
| cs_n | input | 1 | Port select, active low |
| en | input | 1 | Access enable |
| wr_sel | input | 1 | 1 = write, 0 = read |
| mbx_sel | input | 1 | 1 = mailbox access, 0 = FIFO access |
| err_n | output | 1 | Parity error flag, active low |
| rd_dout | output | 36 | Registered read word |

## Verification
The bench builds the block with its default parameters: four lanes of nine bits. That brings the lane boundaries at bits 8, 17, 26 and 35 within reach, as well as the shared-tree switch between checking and mailbox generation. Directed words place single errors in each lane under both parity types. Long random stretches then mix every control combination, including generating mailbox reads with corrupt port data, against a behavioural model compared on every clock.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        TM_IDLE    = 2'd0,
        TM_CHECK   = 2'd1,
        TM_MBX_GEN = 2'd2
    } tree_mode_e;

    // True when every lane of w carries correct parity for the given type.
    function automatic logic word_lanes_ok(input logic [WORD_W-1:0] w, input logic odd);
        logic ok;
        ok = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if ((^w[k*LANE_W +: LANE_W]) != odd) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/lane_parity_trees.sv
module lane_parity_trees
    import lane_parity_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int L_W     = LANE_W,
    localparam int W      = N_LANES * L_W,
    localparam int D_W    = L_W - 1
) (
    input  logic [W-1:0]       word,
    input  logic               odd_sel,
    output logic [N_LANES-1:0] par_bit,
    output logic [N_LANES-1:0] lane_bad
);
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        logic [D_W-1:0] data;
        assign data        = word[k*L_W +: D_W];
        assign par_bit[k]  = (^data) ^ odd_sel;
        assign lane_bad[k] = par_bit[k] != word[k*L_W + D_W];
    end
endmodule

// File: rtl/lane_mode_decode.sv
module lane_mode_decode
    import lane_parity_pkg::*;
(
    input  logic       cs_n,
    input  logic       en,
    input  logic       wr_sel,
    input  logic       mbx_sel,
    input  logic       gen_en,
    output tree_mode_e mode,
    output logic       rd_strobe
);
    assign rd_strobe = !cs_n && en && !wr_sel;

    always_comb begin
        if (cs_n)
            mode = TM_IDLE;
        else if (rd_strobe && mbx_sel && gen_en)
            mode = TM_MBX_GEN;
        else
            mode = TM_CHECK;
    end
endmodule

// File: rtl/lane_parity_top.sv
module lane_parity_top
    import lane_parity_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int L_W     = LANE_W,
    localparam int W      = N_LANES * L_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port_din,
    input  logic [W-1:0] fifo_word,
    input  logic [W-1:0] mbox_word,
    input  logic         odd_sel,
    input  logic         gen_en,
    input  logic         cs_n,
    input  logic         en,
    input  logic         wr_sel,
    input  logic         mbx_sel,
    output logic         err_n,
    output logic [W-1:0] rd_dout
);
    tree_mode_e         mode;
    logic               rd_strobe;
    logic [W-1:0]       shared_in;
    logic [N_LANES-1:0] sh_par, sh_bad;
    logic [N_LANES-1:0] ff_par, ff_bad;
    logic [W-1:0]       rd_next;

    lane_mode_decode i_dec (
        .cs_n(cs_n), .en(en), .wr_sel(wr_sel), .mbx_sel(mbx_sel),
        .gen_en(gen_en), .mode(mode), .rd_strobe(rd_strobe)
    );

    // Shared trees: check the port word, or generate for mailbox reads.
    assign shared_in = (mode == TM_MBX_GEN) ? mbox_word : port_din;

    lane_parity_trees #(.N_LANES(N_LANES), .L_W(L_W)) i_shared (
        .word(shared_in), .odd_sel(odd_sel), .par_bit(sh_par), .lane_bad(sh_bad)
    );

    // Dedicated trees for FIFO-read generation.
    lane_parity_trees #(.N_LANES(N_LANES), .L_W(L_W)) i_fifo_gen (
        .word(fifo_word), .odd_sel(odd_sel), .par_bit(ff_par), .lane_bad(ff_bad)
    );

    always_comb begin
        unique case (mode)
            TM_IDLE:    err_n = 1'b1;
            TM_MBX_GEN: err_n = 1'b1;
            TM_CHECK:   err_n = ~(|sh_bad);
            default:    err_n = 1'b1;
        endcase
    end

    always_comb begin
        rd_next = mbx_sel ? mbox_word : fifo_word;
        if (gen_en) begin
            for (int k = 0; k < N_LANES; k++)
                rd_next[k*L_W + L_W - 1] = mbx_sel ? sh_par[k] : ff_par[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_dout <= '0;
        else if (rd_strobe)
            rd_dout <= rd_next;
    end

    AST_IDLE_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> err_n);                                                     // R7
    AST_MBX_GEN_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && en && !wr_sel && mbx_sel && gen_en) |-> err_n);          // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_n && en && !wr_sel) |=> $stable(rd_dout));                    // R8
    AST_GEN_PARITY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && en && !wr_sel && gen_en) |=> word_lanes_ok(rd_dout, $past(odd_sel))); // R4
    AST_PASS_MBOX: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && en && !wr_sel && !gen_en && mbx_sel) |=> rd_dout == $past(mbox_word)); // R5
    AST_ERR_SOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n) |-> (!cs_n && !word_lanes_ok(port_din, odd_sel)));         // R1
endmodule

// File: tb/test_lane_parity_top.sv
module test_lane_parity_top;
    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] port_din = '0, fifo_word = '0, mbox_word = '0;
    logic         odd_sel = 1'b0, gen_en = 1'b0, cs_n = 1'b1, en = 1'b0;
    logic         wr_sel = 1'b1, mbx_sel = 1'b0;
    logic         err_n;
    logic [W-1:0] rd_dout;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0] exp_rd = '0;
    bit   last_strobe = 0;
    bit   last_gen = 0;

    always #2.5 clk = ~clk;

    lane_parity_top i_lane_parity_top (
        .clk(clk), .rst_n(rst_n), .port_din(port_din), .fifo_word(fifo_word),
        .mbox_word(mbox_word), .odd_sel(odd_sel), .gen_en(gen_en), .cs_n(cs_n),
        .en(en), .wr_sel(wr_sel), .mbx_sel(mbx_sel), .err_n(err_n), .rd_dout(rd_dout)
    );

    function automatic int ones(input logic [W-1:0] w, input int lo, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) if (w[lo+i]) c++;
        return c;
    endfunction

    function automatic logic model_err_n();
        if (cs_n) return 1'b1;
        if (en && !wr_sel && mbx_sel && gen_en) return 1'b1;
        for (int k = 0; k < 4; k++) begin
            int c = ones(port_din, k*9, 9);
            if (odd_sel ? (c % 2 == 0) : (c % 2 == 1)) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [W-1:0] model_rd();
        logic [W-1:0] s = mbx_sel ? mbox_word : fifo_word;
        if (gen_en) begin
            for (int k = 0; k < 4; k++) begin
                int c = ones(s, k*9, 8);
                s[k*9+8] = odd_sel ? (c % 2 == 0) : (c % 2 == 1);
            end
        end
        return s;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_rd <= '0;
            last_strobe <= 0;
        end else begin
            last_strobe <= !cs_n && en && !wr_sel;
            last_gen <= gen_en;
            if (!cs_n && en && !wr_sel) exp_rd <= model_rd();
        end
    end

    task automatic compare(input string lbl);
        string etag, rtag;
        logic e;
        e = model_err_n();
        if (cs_n) etag = "R7";
        else if (en && !wr_sel && mbx_sel && gen_en) etag = "R6";
        else etag = "R1";
        if (!rst_n) rtag = "R8";
        else if (!last_strobe) rtag = "R8";
        else rtag = last_gen ? "R3" : "R5";
        n_tests++;
        if (err_n !== e) begin
            n_fail++;
            $display("FAIL %s/%s err_n got %0b exp %0b", etag, lbl, err_n, e);
        end
        n_tests++;
        if (rd_dout !== exp_rd) begin
            n_fail++;
            $display("FAIL %s/%s rd_dout got %h exp %h", rtag, lbl, rd_dout, exp_rd);
        end
    endtask

    // Apply inputs after a falling edge, then compare just before the next one.
    task automatic step(input string lbl, input logic [W-1:0] pd, input logic [W-1:0] fw,
                        input logic [W-1:0] mw, input logic od, input logic g,
                        input logic c, input logic e, input logic wr, input logic mb);
        @(negedge clk);
        port_din = pd; fifo_word = fw; mbox_word = mw;
        odd_sel = od; gen_en = g; cs_n = c; en = e; wr_sel = wr; mbx_sel = mb;
        #1 compare(lbl);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 compare("R8_reset");
        @(negedge clk); rst_n = 1'b1;
        // R2: all-zero word passes even, fails odd
        step("R2_even_zero", '0, '0, '0, 0, 0, 0, 1, 1, 0);
        step("R2_odd_zero",  '0, '0, '0, 1, 0, 0, 1, 1, 0);
        // R1: single bad lane at each boundary bit, even mode
        for (int k = 0; k < 4; k++) begin
            step("R1_lane_bad", 36'h1 << (k*9+8), '0, '0, 0, 0, 0, 1, 1, 0);
            step("R1_lane_bad_data", 36'h1 << (k*9), '0, '0, 0, 0, 0, 1, 1, 0);
        end
        // R7: deselected with bad data
        step("R7_deselect", 36'h1, '0, '0, 0, 0, 1, 1, 1, 0);
        // R6: mailbox generating read with corrupt port word
        step("R6_mbx_gen", 36'h1, '0, 36'h0_1234_5678, 0, 1, 0, 1, 0, 1);
        step("R6_mbx_gen_odd", 36'h2, '0, 36'hF_0F0F_0F0F, 1, 1, 0, 1, 0, 1);
        // R5: passthrough keeps top bits
        step("R5_pass_fifo", '0, 36'hF_FFFF_FFFF, '0, 0, 0, 0, 1, 0, 0);
        // R9: source selection
        step("R9_mbox", '0, 36'hA_AAAA_AAAA, 36'h5_5555_5555, 0, 0, 0, 1, 0, 1);
        step("R9_fifo", '0, 36'hA_AAAA_AAAA, 36'h5_5555_5555, 0, 0, 0, 1, 0, 0);
        // R3, R4: FIFO generation both types
        step("R4_fifo_gen_even", '0, 36'h1_0203_0407, '0, 0, 1, 0, 1, 0, 0);
        step("R4_fifo_gen_odd",  '0, 36'h1_0203_0407, '0, 1, 1, 0, 1, 0, 0);
        step("R3_settle", '0, '0, '0, 0, 0, 1, 0, 0, 0);
        step("R8_hold", 36'h7, 36'h3, 36'h3, 0, 1, 0, 0, 0, 0);
        step("R8_hold2", '0, '0, '0, 0, 0, 0, 1, 1, 0);
        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] a, b, m;
            int ctl;
            a = {$urandom(), $urandom()}; b = {$urandom(), $urandom()};
            m = {$urandom(), $urandom()}; ctl = $urandom();
            if (ctl[8]) a = '0;
            step("rand", a, b, m, ctl[0], ctl[1], ctl[2] & ctl[7], ctl[3] | ctl[6],
                 ctl[4], ctl[5]);
        end
        @(negedge clk); rst_n = 1'b0;
        #1 compare("R8_reset_again");
        finish_run();
    end
endmodule